// File: doc/BRIEF.md
# Core Clock Source Selector and Rate Divider

This block decides on which cycles of a fast reference clock the CPU core may advance. Three candidate timing sources arrive as single-cycle tick pulses on that one clock: a multiplied PLL output, the main crystal oscillator (or an external signal fed into the oscillator pin), and a slow real-time-clock source. An 8-bit speed register picks one of these sources, holds the power-down controls for the PLL and the oscillator, and chooses a division ratio. The block counts ticks from the chosen source and raises a one-cycle core clock enable once every N ticks.

Software cannot write the speed register directly. It changes in only three ways. A speed instruction loads its 8-bit operand into the register. Taking an interrupt saves the current value in a one-deep shadow and loads a fixed interrupt setting. Returning from the interrupt copies the shadow back. The two power-down bits are brought out unchanged so that the analog blocks can be stopped. The full register is visible read-only.

A new division ratio is adopted only when the current divided period ends. Because of this, a rate change never produces a short core period.

Top module: `cpu_tick_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the register view equals the parameter RST_CFG (default 8'h00) and core_en_o is low until the first divided period completes.
- R2: A speed-load strobe writes spd_val_i into the register at the next rising edge. pll_stop_o always equals register bit 7 and osc_stop_o always equals register bit 6.
- R3: When none of the three strobes is high, the register holds its value whatever spd_val_i does.
- R4: An interrupt-entry strobe copies the current register into the shadow and loads the parameter IRQ_CFG (default 8'h10). Entry has priority over a simultaneous return or speed load.
- R5: An interrupt-return strobe (without entry) copies the shadow back into the register. Return has priority over a simultaneous speed load.
- R6: Register bits 5:4 select the tick source: 00 the PLL tick, 01 the oscillator tick, 10 the real-time-clock tick. Ticks from the sources that are not selected have no effect. With 11 no tick is counted and core_en_o stays low.
- R7: Bit 7 = 1 (PLL stopped) blocks PLL ticks, and bit 6 = 1 (oscillator stopped) blocks oscillator ticks, including those from the external oscillator input. 0 means running.
- R8: Divisor codes in bits 3:0 from 0 to 10 give ratios 1, 2, 3, 4, 5, 6, 8, 10, 12, 16 and 24. core_en_o is high for exactly the one cycle after every Nth counted tick.
- R9: Divisor codes 11 to 15 give the ratio 24.
- R10: A new ratio takes effect only when the current period ends, so the period in progress completes with the ratio it started with.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pll_tick_i | input | 1 | PLL source tick pulse |
| osc_tick_i | input | 1 | Oscillator / external oscillator tick pulse |
| rtc_tick_i | input | 1 | Real-time-clock source tick pulse |
| spd_load_i | input | 1 | Speed instruction strobe |
| spd_val_i | input | 8 | Speed instruction operand |
| irq_enter_i | input | 1 | Interrupt entry strobe |
| irq_leave_i | input | 1 | Interrupt return strobe |
| core_en_o | output | 1 | Core clock enable, one cycle per divided period |
| pll_stop_o | output | 1 | PLL power-down (register bit 7) |
| osc_stop_o | output | 1 | Oscillator power-down (register bit 6) |
| spd_view_o | output | 8 | Read-only view of the speed register |

## Verification
Each result has a fixed latency. core_en_o rises one cycle after the rising edge that counts the Nth selected tick. The register view and the two stop outputs change one cycle after the edge that samples a strobe. A tick is always gated by the register value from before that same edge. The bench model therefore steps once on each rising edge: it reads the inputs held since the previous falling edge and pushes the expected enable and register value into a queue. The monitor pops that entry at the following falling edge and compares it, so every cycle is checked at the exact cycle in which each output is due.

// File: rtl/tick_pkg.sv
package tick_pkg;

  localparam int CFG_W      = 8;
  localparam int DIV_CODE_W = 4;
  localparam int MAX_RATIO  = 24;
  localparam int CNT_W      = $clog2(MAX_RATIO + 1);

  typedef enum logic [1:0] {
    SRC_PLL  = 2'b00,
    SRC_OSC  = 2'b01,
    SRC_RTC  = 2'b10,
    SRC_NONE = 2'b11
  } src_sel_e;

  typedef struct packed {
    logic                  pll_stop;
    logic                  osc_stop;
    src_sel_e              src;
    logic [DIV_CODE_W-1:0] div;
  } spd_cfg_t;

  // Divisor code to ratio: codes below 6 give code+1, then 8, 10, 12, 16, and 24 for all higher codes.
  function automatic logic [CNT_W-1:0] ratio_of(input logic [DIV_CODE_W-1:0] code);
    logic [CNT_W-1:0] r;
    if (code < DIV_CODE_W'(6)) begin
      r = CNT_W'(code) + CNT_W'(1);
    end else begin
      case (code)
        DIV_CODE_W'(6):  r = CNT_W'(8);
        DIV_CODE_W'(7):  r = CNT_W'(10);
        DIV_CODE_W'(8):  r = CNT_W'(12);
        DIV_CODE_W'(9):  r = CNT_W'(16);
        default:         r = CNT_W'(MAX_RATIO);
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/spd_regfile.sv
module spd_regfile
  import tick_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_CFG = 8'h00,
  parameter logic [CFG_W-1:0] IRQ_CFG = 8'h10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CFG_W-1:0] load_val_i,
  input  logic             irq_enter_i,
  input  logic             irq_leave_i,
  output spd_cfg_t         cfg_o
);

  spd_cfg_t cfg_q, shadow_q;

  // Strobe priority: entry, then return, then speed load.
  wire take_irq  = irq_enter_i;
  wire take_ret  = irq_leave_i && !irq_enter_i;
  wire take_load = load_i && !irq_enter_i && !irq_leave_i;
  wire any_upd   = take_irq || take_ret || take_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= spd_cfg_t'(RST_CFG);
      shadow_q <= spd_cfg_t'(RST_CFG);
    end else if (take_irq) begin
      shadow_q <= cfg_q;
      cfg_q    <= spd_cfg_t'(IRQ_CFG);
    end else if (take_ret) begin
      cfg_q    <= shadow_q;
    end else if (take_load) begin
      cfg_q    <= spd_cfg_t'(load_val_i);
    end
  end

  assign cfg_o = cfg_q;

  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_enter_i || irq_leave_i || load_i) |=> $stable(cfg_q));

  // R4
  irq_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_enter_i |=> (cfg_q == spd_cfg_t'(IRQ_CFG)));

  // R4
  irq_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_enter_i |=> (shadow_q == $past(cfg_q)));

  // R5
  ret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_leave_i && !irq_enter_i) |=> (cfg_q == $past(shadow_q)));

  // R2
  spd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !irq_enter_i && !irq_leave_i) |=> (cfg_q == spd_cfg_t'($past(load_val_i))));

endmodule

// File: rtl/tick_select.sv
module tick_select
  import tick_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_sel_e sel_i,
  input  logic     pll_stop_i,
  input  logic     osc_stop_i,
  input  logic     pll_tick_i,
  input  logic     osc_tick_i,
  input  logic     rtc_tick_i,
  output logic     tick_o
);

  // A stopped source delivers nothing, whichever pin feeds it.
  wire pll_live = pll_tick_i && !pll_stop_i;
  wire osc_live = osc_tick_i && !osc_stop_i;

  always_comb begin
    case (sel_i)
      SRC_PLL: tick_o = pll_live;
      SRC_OSC: tick_o = osc_live;
      SRC_RTC: tick_o = rtc_tick_i;
      default: tick_o = 1'b0;
    endcase
  end

  // R7
  pll_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == SRC_PLL && pll_stop_i) |-> !tick_o);

  // R7
  osc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == SRC_OSC && osc_stop_i) |-> !tick_o);

  // R6
  src_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == SRC_NONE) |-> !tick_o);

endmodule

// File: rtl/tick_divider.sv
module tick_divider
  import tick_pkg::*;
#(
  parameter logic [CNT_W-1:0] RST_RATIO = CNT_W'(1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] ratio_i,
  output logic             en_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cur_n_q;
  logic             en_q;

  // Last tick of the running period: the new ratio is adopted here.
  wire period_end = tick_i && (cnt_q == cur_n_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      cur_n_q <= RST_RATIO;
      en_q    <= 1'b0;
    end else begin
      en_q <= period_end;
      if (period_end) begin
        cnt_q   <= '0;
        cur_n_q <= ratio_i;
      end else if (tick_i) begin
        cnt_q   <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign en_o = en_q;

  // R6
  no_tick_no_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> !en_q);

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < cur_n_q);

  // R10
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(cur_n_q));

  // R8
  ratio_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_n_q != '0);

endmodule

// File: rtl/cpu_tick_ctrl.sv
module cpu_tick_ctrl
  import tick_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_CFG = 8'h00,
  parameter logic [CFG_W-1:0] IRQ_CFG = 8'h10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pll_tick_i,
  input  logic             osc_tick_i,
  input  logic             rtc_tick_i,
  input  logic             spd_load_i,
  input  logic [CFG_W-1:0] spd_val_i,
  input  logic             irq_enter_i,
  input  logic             irq_leave_i,
  output logic             core_en_o,
  output logic             pll_stop_o,
  output logic             osc_stop_o,
  output logic [CFG_W-1:0] spd_view_o
);

  localparam spd_cfg_t         RST_FIELDS = spd_cfg_t'(RST_CFG);
  localparam logic [CNT_W-1:0] RST_RATIO  = ratio_of(RST_FIELDS.div);

  spd_cfg_t         cfg;
  logic             sel_tick;
  logic [CNT_W-1:0] cfg_ratio;

  spd_regfile #(
    .RST_CFG (RST_CFG),
    .IRQ_CFG (IRQ_CFG)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (spd_load_i),
    .load_val_i  (spd_val_i),
    .irq_enter_i (irq_enter_i),
    .irq_leave_i (irq_leave_i),
    .cfg_o       (cfg)
  );

  tick_select u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (cfg.src),
    .pll_stop_i (cfg.pll_stop),
    .osc_stop_i (cfg.osc_stop),
    .pll_tick_i (pll_tick_i),
    .osc_tick_i (osc_tick_i),
    .rtc_tick_i (rtc_tick_i),
    .tick_o     (sel_tick)
  );

  assign cfg_ratio = ratio_of(cfg.div);

  tick_divider #(
    .RST_RATIO (RST_RATIO)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (sel_tick),
    .ratio_i (cfg_ratio),
    .en_o    (core_en_o)
  );

  assign pll_stop_o = cfg.pll_stop;
  assign osc_stop_o = cfg.osc_stop;
  assign spd_view_o = cfg;

endmodule

// File: tb/sim_cpu_tick_ctrl.sv
module sim_cpu_tick_ctrl;

  localparam logic [7:0] RST_V = 8'h00;
  localparam logic [7:0] IRQ_V = 8'h10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pll_t = 1'b0, osc_t = 1'b0, rtc_t = 1'b0;
  logic       spd_ld = 1'b0;
  logic [7:0] spd_v = 8'h00;
  logic       irq_in = 1'b0, irq_out = 1'b0;
  wire        core_en, pll_stop, osc_stop;
  wire  [7:0] view;

  always #5 clk = ~clk;

  cpu_tick_ctrl #(.RST_CFG(RST_V), .IRQ_CFG(IRQ_V)) u0 (
    .clk(clk), .rst_n(rst_n),
    .pll_tick_i(pll_t), .osc_tick_i(osc_t), .rtc_tick_i(rtc_t),
    .spd_load_i(spd_ld), .spd_val_i(spd_v),
    .irq_enter_i(irq_in), .irq_leave_i(irq_out),
    .core_en_o(core_en), .pll_stop_o(pll_stop), .osc_stop_o(osc_stop),
    .spd_view_o(view)
  );

  typedef struct {
    bit       en;
    bit [7:0] cfg;
    string    tag;
  } item_t;

  item_t q[$];
  int    vecs = 0;
  int    bad  = 0;
  string phase = "R1 reset";
  int    rtab [16] = '{1, 2, 3, 4, 5, 6, 8, 10, 12, 16, 24, 24, 24, 24, 24, 24};

  bit [7:0] m_cfg, m_shd;
  int       m_cnt, m_n;

  // Reference model: one step per rising edge, expectation due at the next falling edge.
  always @(posedge clk) begin : model
    item_t it;
    bit    t;
    bit    e;
    e = 1'b0;
    if (!rst_n) begin
      m_cfg = RST_V; m_shd = RST_V; m_cnt = 0; m_n = rtab[RST_V[3:0]];
    end else begin
      case (m_cfg[5:4])
        2'b00:   t = pll_t && !m_cfg[7];
        2'b01:   t = osc_t && !m_cfg[6];
        2'b10:   t = rtc_t;
        default: t = 1'b0;
      endcase
      if (t) begin
        if (m_cnt + 1 == m_n) begin
          e = 1'b1; m_cnt = 0; m_n = rtab[m_cfg[3:0]];
        end else begin
          m_cnt = m_cnt + 1;
        end
      end
      if (irq_in) begin
        m_shd = m_cfg; m_cfg = IRQ_V;
      end else if (irq_out) begin
        m_cfg = m_shd;
      end else if (spd_ld) begin
        m_cfg = spd_v;
      end
    end
    it.en = e; it.cfg = m_cfg; it.tag = phase;
    q.push_back(it);
  end

  always @(negedge clk) begin : monitor
    item_t it;
    if (q.size() > 0) begin
      it = q.pop_front();
      vecs++;
      if (core_en !== it.en) begin
        bad++;
        $display("FAIL %s: core_en=%0b expected %0b at %0t", it.tag, core_en, it.en, $time);
      end
      if (view !== it.cfg) begin
        bad++;
        $display("FAIL %s: view=%02h expected %02h at %0t", it.tag, view, it.cfg, $time);
      end
      if (pll_stop !== it.cfg[7] || osc_stop !== it.cfg[6]) begin
        bad++;
        $display("FAIL R2 stop pins: pll=%0b osc=%0b expected %0b %0b at %0t",
                 pll_stop, osc_stop, it.cfg[7], it.cfg[6], $time);
      end
    end
  end

  task automatic ticks(input string tag, input int n, input bit [2:0] m, input int gap);
    phase = tag;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      {pll_t, osc_t, rtc_t} = ((i % gap) == 0) ? m : 3'b000;
    end
    @(negedge clk);
    {pll_t, osc_t, rtc_t} = 3'b000;
  endtask

  task automatic pulse(input string tag, input bit ld, input bit [7:0] v,
                       input bit ent, input bit lv);
    @(negedge clk);
    phase = tag; spd_ld = ld; spd_v = v; irq_in = ent; irq_out = lv;
    @(negedge clk);
    spd_ld = 1'b0; irq_in = 1'b0; irq_out = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ticks("R1 reset value, divide-by-1 on PLL", 10, 3'b100, 1);

    for (int c = 0; c < 16; c++) begin
      pulse("R2 speed load", 1'b1, {4'b0010, 4'(c)}, 1'b0, 1'b0);
      ticks($sformatf("%s code %0d", (c < 11) ? "R8" : "R9", c), 90, 3'b001, (c % 3) + 1);
    end

    pulse("R2 select PLL div1", 1'b1, 8'h00, 1'b0, 1'b0);
    ticks("R6 PLL selected, other sources ignored", 60, 3'b011, 1);
    ticks("R6 PLL ticks counted", 30, 3'b100, 1);
    pulse("R2 select osc div2", 1'b1, 8'h11, 1'b0, 1'b0);
    ticks("R6 osc selected, other sources ignored", 20, 3'b101, 1);
    ticks("R6 osc ticks counted", 30, 3'b010, 1);
    pulse("R2 select off", 1'b1, 8'h31, 1'b0, 1'b0);
    ticks("R6 source off holds enable low", 30, 3'b111, 1);

    pulse("R2 PLL stopped", 1'b1, 8'h80, 1'b0, 1'b0);
    ticks("R7 stopped PLL blocks ticks", 20, 3'b100, 1);
    pulse("R2 osc stopped", 1'b1, 8'h50, 1'b0, 1'b0);
    ticks("R7 stopped osc blocks ticks", 20, 3'b010, 1);
    pulse("R2 osc running, PLL stopped", 1'b1, 8'h90, 1'b0, 1'b0);
    ticks("R7 osc runs while PLL stopped", 20, 3'b110, 1);

    pulse("R2 PLL div10", 1'b1, 8'h07, 1'b0, 1'b0);
    ticks("R10 settle on div10", 30, 3'b100, 1);
    ticks("R10 partial period", 4, 3'b100, 1);
    pulse("R10 change to div2 mid-period", 1'b1, 8'h01, 1'b0, 1'b0);
    ticks("R10 old period completes then div2", 30, 3'b100, 1);

    pulse("R2 rtc div4", 1'b1, 8'h23, 1'b0, 1'b0);
    ticks("R8 rtc div4", 20, 3'b001, 1);
    pulse("R4 interrupt entry", 1'b0, 8'h00, 1'b1, 1'b0);
    ticks("R4 interrupt setting active", 20, 3'b011, 1);
    pulse("R5 interrupt return", 1'b0, 8'h00, 1'b0, 1'b1);
    ticks("R5 restored setting active", 20, 3'b011, 1);
    pulse("R4 entry wins over return and load", 1'b1, 8'h2F, 1'b1, 1'b1);
    ticks("R4 after combined strobes", 5, 3'b000, 1);
    pulse("R5 return wins over load", 1'b1, 8'h35, 1'b0, 1'b1);
    ticks("R5 after return and load", 5, 3'b000, 1);

    phase = "R3 operand without strobe ignored";
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      spd_v = 8'(i * 37 + 5);
      rtc_t = i[0];
    end
    @(negedge clk);
    rtc_t = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule